// File: doc/BRIEF.md
# Seeded One-Hot Ring Scanner

This block drives eight LEDs one at a time, fast enough that all of them appear lit. It holds a circular shift register in which a single 1 travels from stage to stage on every rising clock edge. The serial input of the first stage is the OR of a seed input and the output of the last stage. Once one 1 has been injected, it therefore keeps circulating without further help.

A small sequencer replaces the analog delay circuits such a ring would otherwise need at start-up. After the active-low reset is released, it walks through four states. CLEAR holds every stage at zero for `RST_HOLD` cycles. LOAD lasts one cycle and shifts a forced 1 into the first stage. SETTLE waits `SEED_HOLD` cycles with shifting paused, while the injected seed is taken to be falling away. RUN shifts on every clock. The transitions are CLEAR→LOAD when the hold count expires, LOAD→SETTLE unconditionally, and SETTLE→RUN when the settle count expires. RUN is left only through reset.

The `RECOVER` parameter selects whether the ring is self-correcting. When it is set, a ring found in RUN with any count of ones other than one is forced back to a single 1 in the first stage.

Top module: `ring_scan_top`

## Requirements
- R1: While `rst_n` is low, `leds` is all zeros, whatever the state of the clock. This holds at once on assertion, without waiting for a clock edge.
- R2: For the first `RST_HOLD` rising edges after `rst_n` rises (state CLEAR), `leds` stays all zeros, even when `seed` is high.
- R3: At the next edge (state LOAD), `leds` becomes 1 in bit 0 only (`leds == 1`), whatever the level of `seed`.
- R4: For the following `SEED_HOLD` edges (state SETTLE), `leds` does not change, even when `seed` is high.
- R5: In RUN, each rising edge moves every bit of `leds` from index k to index k+1, and bit N-1 moves to bit 0.
- R6: In RUN, bit 0 after an edge equals `seed` OR the value of bit N-1 before that edge, so a high `seed` adds a 1 to the ring.
- R7: With `RECOVER` = 1, at a RUN edge where `leds` does not hold exactly one 1, `leds` becomes `1` (bit 0 only) at that edge, whatever `seed` is.
- R8: With `RECOVER` = 0, a ring in RUN that holds more than one 1 keeps rotating as in R5/R6 and is never corrected.
- R9: In RUN with `seed` low, a one-hot ring stays one-hot on every edge and visits all N outputs in N edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the ring and restarts the sequencer in CLEAR |
| seed | input | 1 | Extra serial data, ORed into the first stage on every shift |
| leds | output | N | Ring contents, one bit per LED; bit 0 is the first stage |

## Verification
The bench builds two copies with N = 8, RST_HOLD = 3 and SEED_HOLD = 2: one with RECOVER = 1 and one with RECOVER = 0. The short hold counts make the whole start-up sequence take only a handful of edges. This lets every edge of CLEAR, LOAD and SETTLE be checked against a value computed from the edge number, including edges where the seed is held high. Several full laps of RUN cover all eight positions. Seed pulses are injected in RUN while bit 7 is clear, which duplicates the 1. This shows the one-cycle recovery in one copy and the uncorrected double bit rotating in the other. A reset asserted in the middle of a cycle is checked without any clock edge.

// File: rtl/ring_scan_pkg.sv
package ring_scan_pkg;
    typedef enum logic [1:0] {
        PH_CLEAR  = 2'd0,
        PH_LOAD   = 2'd1,
        PH_SETTLE = 2'd2,
        PH_RUN    = 2'd3
    } phase_t;
endpackage

// File: rtl/ring_scan_seq.sv
module ring_scan_seq
    import ring_scan_pkg::*;
#(
    parameter int RST_HOLD  = 10000,
    parameter int SEED_HOLD = 50000
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   clear,
    output logic   shift_en,
    output logic   inject,
    output logic   run
);
    localparam int MAXH = (RST_HOLD > SEED_HOLD) ? RST_HOLD : SEED_HOLD;
    localparam int CW   = (MAXH < 2) ? 1 : $clog2(MAXH + 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(RST_HOLD - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SEED_HOLD - 1);

    phase_t        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_CLEAR: begin
                if (cnt_q == CLR_LAST) begin
                    state_d = PH_LOAD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_LOAD: begin
                state_d = PH_SETTLE;
                cnt_d   = '0;
            end
            PH_SETTLE: begin
                if (cnt_q == SET_LAST) begin
                    state_d = PH_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_RUN: begin
                state_d = PH_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        clear    = 1'b0;
        shift_en = 1'b0;
        inject   = 1'b0;
        run      = 1'b0;
        unique case (state_q)
            PH_CLEAR:  clear = 1'b1;
            PH_LOAD: begin
                shift_en = 1'b1;
                inject   = 1'b1;
            end
            PH_SETTLE: ;
            PH_RUN: begin
                shift_en = 1'b1;
                run      = 1'b1;
            end
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/ring_scan_reg.sv
module ring_scan_reg #(
    parameter int N       = 8,
    parameter int RECOVER = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         inject,
    input  logic         run,
    input  logic         seed,
    output logic [N-1:0] q
);
    localparam logic [N-1:0] FIRST  = N'(1);
    localparam logic         FIX_ON = (RECOVER != 0);

    logic serial_in;
    logic bad;
    logic fix;

    assign serial_in = q[N-1] | seed | inject;
    assign bad       = ($countones(q) != 1);
    assign fix       = FIX_ON & run & bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (fix) begin
            q <= FIRST;
        end else if (shift_en) begin
            q <= {q[N-2:0], serial_in};
        end
    end
endmodule

// File: rtl/ring_scan_top.sv
module ring_scan_top
    import ring_scan_pkg::*;
#(
    parameter int N         = 8,
    parameter int RST_HOLD  = 10000,
    parameter int SEED_HOLD = 50000,
    parameter int RECOVER   = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    output logic [N-1:0] leds
);
    phase_t phase;
    logic   clear, shift_en, inject, run;

    ring_scan_seq #(
        .RST_HOLD (RST_HOLD),
        .SEED_HOLD(SEED_HOLD)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .clear   (clear),
        .shift_en(shift_en),
        .inject  (inject),
        .run     (run)
    );

    ring_scan_reg #(
        .N      (N),
        .RECOVER(RECOVER)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .shift_en(shift_en),
        .inject  (inject),
        .run     (run),
        .seed    (seed),
        .q       (leds)
    );
endmodule

// File: rtl/ring_scan_chk.sv
module ring_scan_chk
    import ring_scan_pkg::*;
#(
    parameter int N       = 8,
    parameter int RECOVER = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         seed,
    input logic [N-1:0] leds,
    input phase_t       phase
);
    function automatic logic [N-1:0] rot(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]};
    endfunction

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLEAR) |-> (leds == '0));

    assert_load_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |=> (leds == N'(1)));

    assert_settle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETTLE) |=> $stable(leds));

    assert_run_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !seed && $onehot(leds)) |=> (leds == rot($past(leds))));

    assert_seed_adds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && seed && $onehot(leds)) |=> leds[0]);

    assert_run_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !seed && $onehot(leds)) |=> $onehot(leds));

    generate
        if (RECOVER != 0) begin : g_rec
            assert_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (phase == PH_RUN && !$onehot(leds)) |=> (leds == N'(1)));
        end
    endgenerate
endmodule

bind ring_scan_top ring_scan_chk #(
    .N      (N),
    .RECOVER(RECOVER)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .seed (seed),
    .leds (leds),
    .phase(phase)
);

// File: tb/ring_scan_top_bench.sv
`timescale 1ns/1ps
module ring_scan_top_bench;
    localparam int N  = 8;
    localparam int RH = 3;
    localparam int SH = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed = 1'b0;
    logic [N-1:0] leds_r, leds_n;
    logic [N-1:0] exp_r, exp_n;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    ring_scan_top #(.N(N), .RST_HOLD(RH), .SEED_HOLD(SH), .RECOVER(1)) u_ring_scan_top (
        .clk(clk), .rst_n(rst_n), .seed(seed), .leds(leds_r));

    ring_scan_top #(.N(N), .RST_HOLD(RH), .SEED_HOLD(SH), .RECOVER(0)) u_ring_scan_top_norec (
        .clk(clk), .rst_n(rst_n), .seed(seed), .leds(leds_n));

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // expected RUN step, from R5/R6/R7
    function automatic logic [N-1:0] step_exp(input logic [N-1:0] cur, input logic sd, input bit rec);
        if (rec && $countones(cur) != 1) return N'(1);
        return {cur[N-2:0], cur[N-1] | sd};
    endfunction

    // reset release, then start-up sweep; seed pattern chosen by pat
    task automatic startup(input int pat);
        logic [N-1:0] e;
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 1; n <= RH + SH + 1 + 2 * N; n++) begin
            seed = (n <= RH + 1 + SH) ? ((n + pat) % 2 == 0) : 1'b0;
            @(posedge clk);
            #5;
            if (n <= RH) begin
                check("R2 clear", leds_r, '0);
                check("R2 clear norec", leds_n, '0);
            end else if (n == RH + 1) begin
                check("R3 load", leds_r, N'(1));
                check("R3 load norec", leds_n, N'(1));
            end else if (n <= RH + 1 + SH) begin
                check("R4 settle", leds_r, N'(1));
                check("R4 settle norec", leds_n, N'(1));
            end else begin
                e = N'(1) << ((n - (RH + 1 + SH)) % N);
                check("R5 R9 rotate", leds_r, e);
                check("R5 R9 rotate norec", leds_n, e);
            end
        end
        exp_r = leds_r;
        exp_n = leds_n;
    endtask

    task automatic run_step(input logic sd, input string tag);
        seed  = sd;
        exp_r = step_exp(exp_r, sd, 1'b1);
        exp_n = step_exp(exp_n, sd, 1'b0);
        @(posedge clk);
        #5;
        check(tag, leds_r, exp_r);
        check(tag, leds_n, exp_n);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with clocks running
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset", leds_r, '0);
        check("R1 reset norec", leds_n, '0);

        startup(0);

        // R6/R7/R8: duplicate the bit while bit 7 is clear
        for (int k = 0; k < 3; k++) begin
            while (exp_r[N-1] || exp_n[N-1] || $countones(exp_r) != 1)
                run_step(1'b0, "R5 run");
            run_step(1'b1, "R6 seed adds bit");
            run_step(1'b0, "R7 recover / R8 no fix");
            for (int j = 0; j < N + 2; j++)
                run_step(1'b0, "R7 R8 after upset");
        end
        // seed held for several edges
        for (int j = 0; j < 3; j++) run_step(1'b1, "R6 R7 seed held");
        for (int j = 0; j < N; j++) run_step(1'b0, "R7 R8 after held seed");

        // R1: asynchronous reset in mid-cycle
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        #2;
        check("R1 async reset", leds_r, '0);
        check("R1 async reset norec", leds_n, '0);
        repeat (2) @(posedge clk);
        #5;
        check("R1 reset held", leds_r, '0);

        startup(1);
        for (int j = 0; j < N; j++) run_step(1'b0, "R9 full lap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule